// File: doc/BRIEF.md
# Delay-Line Lock Capture and Freeze Sequencer

This block brings a memory PHY delay-locked loop from reset to a frozen, locked delay. On a start pulse it issues an ordered series of single-cycle register writes to two PHY control registers. First comes a fixed initial value for the primary control register, then a caller-supplied word for the secondary register. After that it sets the enable bit and, in a separate write, the run bit. It then watches the PHY status word until all three lock indicators are high.

Once lock is seen, the block takes the coarse lock code from the status word and merges it into the top byte of the primary control register. This last write pins the delay at the measured setting. The block then raises a locked flag. If lock does not arrive within a parameterised number of cycles, it stops with an error flag instead and makes no freeze write. A shadow copy of the primary control register is always visible at the ports.

Top module: `dll_force_seq`

## Requirements
- R1: While and after reset, regWrEn, locked, timeoutErr and busy are 0 and ctrl0Value is 0.
- R2: A start pulse in the idle state yields four writes on four consecutive cycles, each a one-cycle regWrEn strobe: primary register (regWrSel=0) with 0x00101000, secondary register (regWrSel=1) with the configuration word, primary with 0x00101002 (enable, bit 1), then primary with 0x00101003 (run, bit 0).
- R3: The configuration word is sampled in the cycle start is accepted. Later changes to phyCfgWord do not alter the secondary write.
- R4: The lock wait ends only when phyStatus[2:0] is 3'b111. A status with only some of these bits set causes no write. Status values present before the run write are ignored.
- R5: Lock seen at a clock edge produces, on the next edge, one primary write of 0x00101003 with phyStatus[13:6] from that lock edge placed in bits 31:24. locked rises together with that write, and busy falls.
- R6: ctrl0Value always equals the data of the most recent primary-register write.
- R7: If lock is not seen within TIMEOUT_CYCLES edges after the run write, timeoutErr rises, busy falls and no freeze write occurs. Lock seen on the last allowed edge is still accepted. locked and timeoutErr are never high together.
- R8: start is ignored while busy. start while locked or in error restarts the full sequence and clears both flags.
- R9: busy is high from the cycle after start is accepted until locked or timeoutErr rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) the lock sequence |
| phyCfgWord | input | DATA_W | Value for the secondary control register |
| phyStatus | input | DATA_W | PHY status word: lock indicators and coarse lock code |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrSel | output | 1 | Write target: 0 primary, 1 secondary |
| regWrData | output | DATA_W | Write data |
| ctrl0Value | output | DATA_W | Last value written to the primary register |
| locked | output | 1 | Delay frozen at the captured lock code |
| timeoutErr | output | 1 | Lock wait expired |
| busy | output | 1 | Sequence in progress |

## Verification
On every cycle, the assertions check these points. At most one write strobe fires at a time. The run bit never appears before the enable bit. The rise of locked coincides with a primary write that carries the status code from two edges earlier. An error only rises when the lock bits were absent, and the two final flags are mutually exclusive. Other points need the bench scenarios. These are the exact write order and data, the capture of the configuration word, the rejection of partial lock patterns, acceptance on the final allowed cycle, ignored start pulses while busy, restarts, and reset in the middle of a sequence.

// File: rtl/dllf_pkg.sv
package dllf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_CFG,
    ST_ON,
    ST_GO,
    ST_WAIT,
    ST_FORCE,
    ST_DONE,
    ST_ERR
  } seqState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic takeCfg;   // latch configuration word
    logic putInit;   // write fixed initial primary value
    logic putCfg;    // write secondary register
    logic putOn;     // write primary with enable bit
    logic putGo;     // write primary with run bit
    logic grabLock;  // latch coarse lock code
    logic putForce;  // write primary with frozen code
  } seqStrobe_t;

  localparam logic SEL_CTRL0 = 1'b0;
  localparam logic SEL_CTRL1 = 1'b1;

endpackage

// File: rtl/dllf_ctrl.sv
module dllf_ctrl
  import dllf_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int LOCK_BITS      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [LOCK_BITS-1:0] lockBits,
  output seqStrobe_t           strobe,
  output logic                 locked,
  output logic                 timeoutErr,
  output logic                 busy
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYCLES - 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic allLocked;
  logic atRest;

  assign allLocked = &lockBits;
  assign atRest    = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERR);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR: if (start) stateNext = ST_INIT;
      ST_INIT:  stateNext = ST_CFG;
      ST_CFG:   stateNext = ST_ON;
      ST_ON:    stateNext = ST_GO;
      ST_GO:    stateNext = ST_WAIT;
      ST_WAIT: begin
        if (allLocked)             stateNext = ST_FORCE;
        else if (waitCnt == LAST_CNT) stateNext = ST_ERR;
      end
      ST_FORCE: stateNext = ST_DONE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.takeCfg  = atRest && start;
    strobe.putInit  = (state == ST_INIT);
    strobe.putCfg   = (state == ST_CFG);
    strobe.putOn    = (state == ST_ON);
    strobe.putGo    = (state == ST_GO);
    strobe.grabLock = (state == ST_WAIT) && allLocked;
    strobe.putForce = (state == ST_FORCE);
  end

  assign locked     = (state == ST_DONE);
  assign timeoutErr = (state == ST_ERR);
  assign busy       = !atRest;

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.putInit, strobe.putCfg, strobe.putOn, strobe.putGo, strobe.putForce})); // R2

  AST_NO_CAPTURE_AT_REST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grabLock |-> busy); // R4

endmodule

// File: rtl/dllf_datapath.sv
module dllf_datapath
  import dllf_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] INIT_VALUE = 32'h0010_1000,
  parameter int              ON_BIT     = 1,
  parameter int              GO_BIT     = 0,
  parameter int              LOCK_LSB   = 6,
  parameter int              LOCK_W     = 8,
  parameter int              FORCE_LSB  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] cfgIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic              wrEn,
  output logic              wrSel,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrl0Value
);

  localparam logic [DATA_W-1:0] ON_MASK = DATA_W'(1) << ON_BIT;
  localparam logic [DATA_W-1:0] GO_MASK = DATA_W'(1) << GO_BIT;

  logic [DATA_W-1:0] cfgReg;
  logic [LOCK_W-1:0] lockVal;
  logic [DATA_W-1:0] shadow, shadowNext;
  logic anyWrite;

  assign anyWrite = strobe.putInit | strobe.putCfg | strobe.putOn |
                    strobe.putGo | strobe.putForce;

  always_comb begin
    shadowNext = shadow;
    if (strobe.putInit)  shadowNext = INIT_VALUE;
    if (strobe.putOn)    shadowNext = shadow | ON_MASK;
    if (strobe.putGo)    shadowNext = shadow | GO_MASK;
    if (strobe.putForce) shadowNext = shadow | (DATA_W'(lockVal) << FORCE_LSB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      lockVal <= '0;
      shadow  <= '0;
      wrEn    <= 1'b0;
      wrSel   <= SEL_CTRL0;
      wrData  <= '0;
    end else begin
      if (strobe.takeCfg)  cfgReg  <= cfgIn;
      if (strobe.grabLock) lockVal <= statusIn[LOCK_LSB +: LOCK_W];
      shadow <= shadowNext;
      wrEn   <= anyWrite;
      wrSel  <= strobe.putCfg ? SEL_CTRL1 : SEL_CTRL0;
      if (!anyWrite)          wrData <= '0;
      else if (strobe.putCfg) wrData <= cfgReg;
      else                    wrData <= shadowNext;
    end
  end

  assign ctrl0Value = shadow;

  AST_GO_AFTER_ON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shadow[GO_BIT]) |-> (shadow[ON_BIT] && $past(shadow[ON_BIT]))); // R2

  AST_SHADOW_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrSel == SEL_CTRL0)) |-> (wrData == shadow)); // R6

endmodule

// File: rtl/dll_force_seq.sv
module dll_force_seq
  import dllf_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int LOCK_BITS      = 3,
  parameter int LOCK_LSB       = 6,
  parameter int LOCK_W         = 8,
  parameter int FORCE_LSB      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] phyCfgWord,
  input  logic [DATA_W-1:0] phyStatus,
  output logic              regWrEn,
  output logic              regWrSel,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] ctrl0Value,
  output logic              locked,
  output logic              timeoutErr,
  output logic              busy
);

  seqStrobe_t strobe;

  dllf_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .LOCK_BITS     (LOCK_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .lockBits  (phyStatus[LOCK_BITS-1:0]),
    .strobe    (strobe),
    .locked    (locked),
    .timeoutErr(timeoutErr),
    .busy      (busy)
  );

  dllf_datapath #(
    .DATA_W    (DATA_W),
    .INIT_VALUE(DATA_W'(32'h0010_1000)),
    .ON_BIT    (1),
    .GO_BIT    (0),
    .LOCK_LSB  (LOCK_LSB),
    .LOCK_W    (LOCK_W),
    .FORCE_LSB (FORCE_LSB)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgIn     (phyCfgWord),
    .statusIn  (phyStatus),
    .wrEn      (regWrEn),
    .wrSel     (regWrSel),
    .wrData    (regWrData),
    .ctrl0Value(ctrl0Value)
  );

  AST_LOCK_WITH_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> (regWrEn && (regWrSel == SEL_CTRL0))); // R5

  AST_FORCE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> (ctrl0Value[FORCE_LSB +: LOCK_W] ==
                       $past(phyStatus[LOCK_LSB +: LOCK_W], 2))); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(locked && timeoutErr)); // R7

  AST_ERR_WITHOUT_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> ($past(phyStatus[LOCK_BITS-1:0]) != {LOCK_BITS{1'b1}})); // R7

endmodule

// File: tb/dll_force_seq_bench.sv
module dll_force_seq_bench;

  localparam int TMO = 12;
  localparam logic [31:0] INIT = 32'h0010_1000;

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] status;
    logic [2:0]  waitBits;
    logic [3:0]  delay;     // 0 = lock never arrives
    logic        preLock;
    logic        pokeStart;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0085, 32'h0000_3FC0, 3'b000, 4'd1,  1'b0, 1'b0},
    '{32'h0000_0086, 32'h0000_1547, 3'b110, 4'd5,  1'b0, 1'b1},
    '{32'h1234_5678, 32'hFFFF_C03F, 3'b011, 4'd12, 1'b0, 1'b0},
    '{32'h0000_0085, 32'h0000_02A7, 3'b000, 4'd1,  1'b1, 1'b0},
    '{32'h0000_00A5, 32'h0000_1FC0, 3'b101, 4'd0,  1'b0, 1'b1},
    '{32'h0000_0086, 32'h0000_2007, 3'b001, 4'd3,  1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] phyCfgWord = '0;
  logic [31:0] phyStatus = '0;
  logic        regWrEn, regWrSel, locked, timeoutErr, busy;
  logic [31:0] regWrData, ctrl0Value;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dll_force_seq #(.TIMEOUT_CYCLES(TMO)) u_dll_force_seq (
    .clk(clk), .rstN(rstN), .start(start), .phyCfgWord(phyCfgWord),
    .phyStatus(phyStatus), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .ctrl0Value(ctrl0Value), .locked(locked),
    .timeoutErr(timeoutErr), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic checkIdleOutputs(input string req);
    check(req, {31'b0, regWrEn}, 32'd0);
    check(req, {31'b0, locked}, 32'd0);
    check(req, {31'b0, timeoutErr}, 32'd0);
    check(req, {31'b0, busy}, 32'd0);
    check(req, ctrl0Value, 32'd0);
  endtask

  task automatic runCase(input vec_t v);
    logic [31:0] expData [4];
    logic        expSel [4];
    logic [31:0] expForce;
    expData = '{INIT, v.cfg, INIT | 32'h2, INIT | 32'h3};
    expSel  = '{1'b0, 1'b1, 1'b0, 1'b0};
    expForce = INIT | 32'h3 | ({24'b0, v.status[13:6]} << 24);
    @(negedge clk);
    phyStatus  = v.preLock ? {v.status[31:3], 3'b111} : {v.status[31:3], v.waitBits};
    phyCfgWord = v.cfg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    phyCfgWord = ~v.cfg;                       // R3: must not leak
    check("R9 busy after start", {31'b0, busy}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      if (v.pokeStart && i == 1) start = 1'b1; // R8: ignored while busy
      @(negedge clk);
      start = 1'b0;
      check("R2 write strobe", {31'b0, regWrEn}, 32'd1);
      check("R2 write target", {31'b0, regWrSel}, {31'b0, expSel[i]});
      check(i == 1 ? "R3 captured config" : "R2 write data", regWrData, expData[i]);
      if (i == 0) begin
        check("R8 flags cleared on restart", {30'b0, locked, timeoutErr}, 32'd0);
      end
    end
    check("R6 shadow after run write", ctrl0Value, INIT | 32'h3);
    if (v.delay == 0) begin
      for (int j = 1; j <= TMO; j++) begin
        @(negedge clk);
        check("R4 no write while waiting", {31'b0, regWrEn}, 32'd0);
        check("R7 error timing", {31'b0, timeoutErr}, (j == TMO) ? 32'd1 : 32'd0);
      end
      check("R7 busy drops on timeout", {31'b0, busy}, 32'd0);
      @(negedge clk);
      check("R7 no freeze write after timeout", {31'b0, regWrEn}, 32'd0);
      check("R7 not locked", {31'b0, locked}, 32'd0);
    end else begin
      for (int j = 1; j < int'(v.delay); j++) begin
        @(negedge clk);
        check("R4 partial lock ignored", {31'b0, regWrEn}, 32'd0);
        check("R9 busy while waiting", {31'b0, busy}, 32'd1);
      end
      phyStatus = {v.status[31:3], 3'b111};
      @(negedge clk);
      phyStatus = 32'h0000_3FC0;               // code changes after the lock edge
      check("R5 no write on lock edge", {31'b0, regWrEn}, 32'd0);
      @(negedge clk);
      check("R5 freeze strobe", {31'b0, regWrEn}, 32'd1);
      check("R5 freeze target", {31'b0, regWrSel}, 32'd0);
      check("R5 freeze data", regWrData, expForce);
      check("R5 locked", {31'b0, locked}, 32'd1);
      check("R9 busy low when locked", {31'b0, busy}, 32'd0);
      check("R6 shadow holds freeze", ctrl0Value, expForce);
      @(negedge clk);
      check("R5 single freeze write", {31'b0, regWrEn}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdleOutputs("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdleOutputs("R1 after reset");

    foreach (VECS[k]) runCase(VECS[k]);

    // Reset in the middle of a sequence
    @(negedge clk);
    phyStatus = 32'h0;
    phyCfgWord = 32'h85;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdleOutputs("R1 reset mid-sequence");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkIdleOutputs("R1 stays idle without start");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule